// File: doc/BRIEF.md
# Extended-to-Double Precision Converter

This block turns an 80-bit extended-precision floating-point value into a 64-bit IEEE 754 double-precision word. The input is a sign bit, a 15-bit exponent with a bias of 16383, and a 64-bit mantissa whose top bit is the explicit integer bit. A 2-bit rounding-mode input selects how the 11 mantissa bits that do not fit are folded into the 52-bit fraction.

Zero and NaN operands take dedicated paths. Every other operand is checked against the exponent range a double can hold. An operand that is out of range is rejected: the block raises an underflow or overflow flag, clears the success flag and returns an all-zero word. The conversion is registered, so a result appears one clock after the operand is presented with `in_valid` high. The rest of a floating-point unit uses the flags to decide whether to complete a store or raise an exception.

Top module: `xd_to_double`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `out_word`, `out_ok`, `out_under` and `out_over` become 0.
- R2: `out_valid` equals `in_valid` from the previous clock. When `in_valid` was low, `out_word`, `out_ok`, `out_under` and `out_over` keep their values.
- R3: An operand whose 64-bit mantissa is all zero gives `out_word` = 0 and `out_ok` = 1, whatever its sign or exponent.
- R4: An operand with exponent 0x7FFF and a non-zero mantissa bits 62:0 is a NaN. It gives `out_ok` = 1, no flags, and a word made of the sign in bit 63, 0x7FF in bits 62:52, 1 in bit 51, and mantissa bits 61:11 in bits 50:0. No rounding and no range check is applied.
- R5: A non-zero, non-NaN operand with mantissa bit 63 clear, or with an exponent below 0x3C00 (unbiased below -1023), gives `out_under` = 1, `out_ok` = 0 and `out_word` = 0. This check takes priority over the overflow check.
- R6: A normalized operand with an exponent above 0x43FE (unbiased above 1023) gives `out_over` = 1, `out_ok` = 0 and `out_word` = 0. This includes infinity (exponent 0x7FFF, mantissa 0x8000000000000000).
- R7: A normalized in-range operand gives `out_ok` = 1. The sign goes in bit 63, the input exponent minus 0x3C00 goes in bits 62:52, and mantissa bits 62:11 go in bits 51:0. The low 11 mantissa bits form the remainder.
- R8: With `rnd_mode` = 2'b00 (nearest), remainder bit 10 set adds 1 to the fraction. If remainder bits 9:0 are also zero (a tie), bit 0 of the word is cleared after the add, which leaves an even fraction.
- R9: With `rnd_mode` = 2'b01 (down), a non-zero remainder adds 1 only to negative operands. With `rnd_mode` = 2'b10 (up), it adds 1 only to positive operands.
- R10: With `rnd_mode` = 2'b11 (chop), the remainder is discarded and nothing is added.
- R11: A rounding add that carries out of the 52-bit fraction increments the exponent field in bits 62:52.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand present this cycle |
| in_sign | input | 1 | Operand sign |
| in_exp | input | 15 | Operand exponent, bias 16383 |
| in_man | input | 64 | Operand mantissa, bit 63 is the integer bit |
| rnd_mode | input | 2 | 00 nearest, 01 down, 10 up, 11 chop |
| out_valid | output | 1 | Result present |
| out_word | output | 64 | Double-precision result |
| out_ok | output | 1 | Conversion succeeded |
| out_under | output | 1 | Exponent too small or operand unnormalized |
| out_over | output | 1 | Exponent too large |

## Verification
Rounding and exponent assembly can both act in the same cycle. A remainder that rounds up an all-ones fraction carries into the exponent field. The bench provokes this with an all-ones mantissa, both at a mid-range exponent and at the largest accepted exponent, where the carry produces 0x7FF with a zero fraction. Ties under nearest mode are applied to both odd and even fractions, so the increment and the following LSB clear can be judged together. Each result is compared on every clock against a behavioural model built from the requirements.

// File: rtl/xd_pkg.sv
package xd_pkg;

    localparam int EXT_EXP_W  = 15;
    localparam int EXT_MAN_W  = 64;
    localparam int DBL_EXP_W  = 11;
    localparam int DBL_FRAC_W = 52;
    localparam int DBL_W      = 1 + DBL_EXP_W + DBL_FRAC_W;
    localparam int BODY_W     = DBL_EXP_W + DBL_FRAC_W;
    localparam int DROP_W     = EXT_MAN_W - 1 - DBL_FRAC_W;
    localparam int EXT_BIAS   = (1 << (EXT_EXP_W - 1)) - 1;
    localparam int DBL_BIAS   = (1 << (DBL_EXP_W - 1)) - 1;
    localparam int EXP_LO     = EXT_BIAS - DBL_BIAS;
    localparam int EXP_HI     = EXT_BIAS + DBL_BIAS;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_CHOP = 2'b11
    } rmode_t;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_NAN,
        CL_UNDER,
        CL_OVER,
        CL_NORM
    } cls_t;

    typedef struct packed {
        logic                 sign;
        logic [EXT_EXP_W-1:0] exp;
        logic [EXT_MAN_W-1:0] man;
    } ext_t;

    typedef struct packed {
        logic                  sign;
        logic [DBL_EXP_W-1:0]  exp;
        logic [DBL_FRAC_W-1:0] frac;
    } dbl_t;

    // Decide whether the truncated magnitude gets one added.
    function automatic logic need_bump(rmode_t rm, logic sign, logic [DROP_W-1:0] rem);
        logic any;
        any = |rem;
        case (rm)
            RM_NEAR: need_bump = rem[DROP_W-1];
            RM_DOWN: need_bump = any & sign;
            RM_UP:   need_bump = any & ~sign;
            default: need_bump = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/xd_classify.sv
module xd_classify
    import xd_pkg::*;
(
    input  ext_t op_i,
    output cls_t cls_o
);
    localparam logic [EXT_EXP_W-1:0] EXP_MAX = '1;
    localparam logic [EXT_EXP_W-1:0] LO_LIM  = EXT_EXP_W'(EXP_LO);
    localparam logic [EXT_EXP_W-1:0] HI_LIM  = EXT_EXP_W'(EXP_HI);

    logic man_zero;
    logic low_nz;
    logic int_bit;

    assign man_zero = (op_i.man == '0);
    assign low_nz   = |op_i.man[EXT_MAN_W-2:0];
    assign int_bit  = op_i.man[EXT_MAN_W-1];

    always_comb begin
        if (man_zero)
            cls_o = CL_ZERO;
        else if (op_i.exp == EXP_MAX && low_nz)
            cls_o = CL_NAN;
        else if (!int_bit || op_i.exp < LO_LIM)
            cls_o = CL_UNDER;
        else if (op_i.exp > HI_LIM)
            cls_o = CL_OVER;
        else
            cls_o = CL_NORM;
    end
endmodule

// File: rtl/xd_round.sv
module xd_round
    import xd_pkg::*;
(
    input  logic              active_i,
    input  rmode_t            rm_i,
    input  logic              sign_i,
    input  logic [BODY_W-1:0] body_i,
    input  logic [DROP_W-1:0] rem_i,
    output logic [BODY_W-1:0] body_o
);
    localparam logic [DROP_W-1:0] TIE = DROP_W'(1) << (DROP_W - 1);

    logic              bump;
    logic              tie;
    logic [BODY_W-1:0] sum;

    assign bump = need_bump(rm_i, sign_i, rem_i);
    assign tie  = (rm_i == RM_NEAR) && (rem_i == TIE);

    always_comb begin
        sum = body_i + BODY_W'(bump);
        if (tie)
            sum[0] = 1'b0;
        body_o = sum;
    end

    // R11: the rounded word is the truncated word or one above it
    always_comb begin
        if (active_i) begin
            round_step_chk: assert (body_o == body_i || body_o == body_i + BODY_W'(1));
        end
    end
endmodule

// File: rtl/xd_to_double.sv
module xd_to_double
    import xd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_sign,
    input  logic [EXT_EXP_W-1:0] in_exp,
    input  logic [EXT_MAN_W-1:0] in_man,
    input  logic [1:0]           rnd_mode,
    output logic                 out_valid,
    output logic [DBL_W-1:0]     out_word,
    output logic                 out_ok,
    output logic                 out_under,
    output logic                 out_over
);
    localparam logic [DBL_EXP_W-1:0] NAN_EXP = '1;
    localparam logic [EXT_EXP_W-1:0] REBIAS  = EXT_EXP_W'(EXP_LO);

    ext_t              op;
    cls_t              cls;
    rmode_t            rm;
    logic [EXT_EXP_W-1:0] exp_shift;
    logic [BODY_W-1:0] body_trunc;
    logic [BODY_W-1:0] body_rnd;
    logic [DROP_W-1:0] rem;
    dbl_t              word_n;
    logic              ok_n, under_n, over_n;

    assign op  = '{sign: in_sign, exp: in_exp, man: in_man};
    assign rm  = rmode_t'(rnd_mode);
    assign rem = op.man[DROP_W-1:0];
    assign exp_shift  = op.exp - REBIAS;
    assign body_trunc = {exp_shift[DBL_EXP_W-1:0], op.man[EXT_MAN_W-2:DROP_W]};

    xd_classify u_cls (
        .op_i  (op),
        .cls_o (cls)
    );

    xd_round u_rnd (
        .active_i (in_valid && cls == CL_NORM),
        .rm_i     (rm),
        .sign_i   (op.sign),
        .body_i   (body_trunc),
        .rem_i    (rem),
        .body_o   (body_rnd)
    );

    always_comb begin
        word_n  = '0;
        ok_n    = 1'b1;
        under_n = 1'b0;
        over_n  = 1'b0;
        case (cls)
            CL_ZERO: ;
            CL_NAN: begin
                word_n.sign = op.sign;
                word_n.exp  = NAN_EXP;
                word_n.frac = {1'b1, op.man[EXT_MAN_W-3:DROP_W]};
            end
            CL_UNDER: begin
                ok_n    = 1'b0;
                under_n = 1'b1;
            end
            CL_OVER: begin
                ok_n   = 1'b0;
                over_n = 1'b1;
            end
            default: begin
                word_n.sign = op.sign;
                {word_n.exp, word_n.frac} = body_rnd;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            out_ok    <= 1'b0;
            out_under <= 1'b0;
            out_over  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word  <= word_n;
                out_ok    <= ok_n;
                out_under <= under_n;
                out_over  <= over_n;
            end
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |->
            ($stable(out_word) && $stable(out_ok) && $stable(out_under) && $stable(out_over)));

    // R5
    fail_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_under || out_over) |-> (out_word == '0 && !out_ok));

    // R6
    status_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_ok, out_under, out_over}));

    // R4
    nan_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (out_ok && out_word[DBL_W-2:DBL_FRAC_W] == NAN_EXP) |->
            (out_word[DBL_FRAC_W-1] || out_word[DBL_FRAC_W-1:0] == '0));
endmodule

// File: tb/sim_xd_to_double.sv
module sim_xd_to_double;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_sign = 1'b0;
    logic [14:0] in_exp = '0;
    logic [63:0] in_man = '0;
    logic [1:0]  rnd_mode = '0;
    logic        out_valid;
    logic [63:0] out_word;
    logic        out_ok, out_under, out_over;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state: what the outputs should hold after the coming edge
    logic        m_valid = 0;
    logic [63:0] m_word  = 0;
    logic        m_ok = 0, m_under = 0, m_over = 0;

    always #4 clk = ~clk;

    xd_to_double u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign),
        .in_exp(in_exp), .in_man(in_man), .rnd_mode(rnd_mode),
        .out_valid(out_valid), .out_word(out_word), .out_ok(out_ok),
        .out_under(out_under), .out_over(out_over)
    );

    task automatic model(input logic s, input logic [14:0] e, input logic [63:0] m,
                         input logic [1:0] rm);
        int          ue;
        logic [63:0] body;
        logic [10:0] rest;
        logic        add;
        m_word = 0; m_ok = 1; m_under = 0; m_over = 0;
        ue = int'(e) - 16383;
        if (m == 0) begin
        end else if (e == 15'h7FFF && m[62:0] != 0) begin
            m_word = {s, 11'h7FF, 1'b1, m[61:11]};
        end else if (!m[63] || ue < -1023) begin
            m_ok = 0; m_under = 1;
        end else if (ue > 1023) begin
            m_ok = 0; m_over = 1;
        end else begin
            rest = m[10:0];
            body = (64'(ue + 1023) << 52) | ((m >> 11) & ((64'd1 << 52) - 1));
            if (rm == 2'b00)      add = rest >= 11'd1024;
            else if (rm == 2'b01) add = (rest != 0) && s;
            else if (rm == 2'b10) add = (rest != 0) && !s;
            else                  add = 0;
            if (add) body = body + 1;
            if (rm == 2'b00 && rest == 11'd1024) body = body & ~64'd1;
            m_word = {s, body[62:0]};
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (out_valid !== m_valid || out_word !== m_word || out_ok !== m_ok ||
            out_under !== m_under || out_over !== m_over) begin
            fails++;
            $display("FAIL %s: got v=%b w=%h ok=%b u=%b o=%b, expected v=%b w=%h ok=%b u=%b o=%b",
                     tag, out_valid, out_word, out_ok, out_under, out_over,
                     m_valid, m_word, m_ok, m_under, m_over);
        end
    endtask

    task automatic step(input logic v, input logic s, input logic [14:0] e,
                        input logic [63:0] m, input logic [1:0] rm, input string tag);
        @(negedge clk);
        in_valid = v; in_sign = s; in_exp = e; in_man = m; rnd_mode = rm;
        m_valid = v;
        if (v) model(s, e, m, rm);
        @(posedge clk);
        #2;
        compare(tag);
    endtask

    localparam logic [63:0] ONE = 64'h8000_0000_0000_0000;

    initial begin
        repeat (3) @(posedge clk);
        #2;
        compare("R1 reset state");
        @(negedge clk);
        rst = 0;
        @(posedge clk);
        #2;
        compare("R1 after reset release");

        step(1, 0, 15'h3FFF, 64'h0, 2'b00, "R3 zero positive");
        step(1, 1, 15'h1234, 64'h0, 2'b10, "R3 zero negative");
        step(1, 0, 15'h3FFF, ONE, 2'b00, "R7 one");
        step(1, 1, 15'h4000, 64'hC000_0000_0000_0000, 2'b11, "R7 minus three");
        step(1, 1, 15'h7FFF, 64'hC123_4567_89AB_CFFF, 2'b00, "R4 nan");
        step(1, 0, 15'h7FFF, 64'h0000_0000_0000_0001, 2'b10, "R4 nan low payload");
        step(1, 0, 15'h7FFF, ONE, 2'b00, "R6 infinity");
        step(1, 0, 15'h43FF, ONE, 2'b00, "R6 exponent 1024");
        step(1, 1, 15'h43FE, ONE | 64'h7FF, 2'b11, "R7 exponent 1023");
        step(1, 0, 15'h3C00, ONE, 2'b00, "R7 exponent -1023");
        step(1, 0, 15'h3BFF, ONE, 2'b00, "R5 exponent -1024");
        step(1, 0, 15'h3FFF, 64'h4000_0000_0000_0000, 2'b00, "R5 unnormalized");
        step(1, 0, 15'h7000, 64'h4000_0000_0000_0000, 2'b00, "R5 priority over R6");
        step(1, 0, 15'h3FFF, ONE | 64'h400, 2'b00, "R8 tie even");
        step(1, 0, 15'h3FFF, ONE | 64'hC00, 2'b00, "R8 tie odd");
        step(1, 0, 15'h3FFF, ONE | 64'h401, 2'b00, "R8 above half");
        step(1, 1, 15'h3FFF, ONE | 64'h3FF, 2'b00, "R8 below half");
        step(1, 1, 15'h3FFF, ONE | 64'h001, 2'b01, "R9 down negative");
        step(1, 0, 15'h3FFF, ONE | 64'h001, 2'b01, "R9 down positive");
        step(1, 0, 15'h3FFF, ONE | 64'h001, 2'b10, "R9 up positive");
        step(1, 1, 15'h3FFF, ONE | 64'h7FF, 2'b10, "R9 up negative");
        step(1, 0, 15'h3FFF, ONE | 64'h7FF, 2'b11, "R10 chop positive");
        step(1, 1, 15'h3FFF, ONE | 64'h7FF, 2'b11, "R10 chop negative");
        step(1, 0, 15'h3FFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00, "R11 carry into exponent");
        step(1, 0, 15'h43FE, 64'hFFFF_FFFF_FFFF_FFFF, 2'b10, "R11 carry at top exponent");
        step(1, 1, 15'h3FFF, 64'hFFFF_FFFF_FFFF_FC00, 2'b00, "R11 tie carry");
        step(0, 1, 15'h4100, 64'hDEAD_BEEF_0000_0000, 2'b00, "R2 idle holds");
        step(0, 0, 15'h0, 64'h0, 2'b11, "R2 idle holds again");
        step(1, 0, 15'h3FFE, ONE, 2'b00, "R2 valid after idle");

        for (int i = 0; i < 40; i++) begin
            logic [63:0] mm;
            mm = {1'b1, 31'(i * 977), 32'(i * 40503 + 7)};
            step(1, i[0], 15'(16300 + i * 5), mm, 2'(i), "R8 R9 R10 sweep");
        end

        step(1, 0, 15'h3FFF, ONE, 2'b00, "R1 before reset");
        @(negedge clk);
        rst = 1; in_valid = 1;
        m_valid = 0; m_word = 0; m_ok = 0; m_under = 0; m_over = 0;
        @(posedge clk);
        #2;
        compare("R1 mid-run reset");
        @(negedge clk);
        rst = 0; in_valid = 0;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule